// File: doc/BRIEF.md
# Operand Read Latency Delay Queue

This block sits between the register-file bank arbiter and the operand collector units. In any cycle the arbiter may hand it one granted operand read per bank. Each read carries the ID of the collector unit that asked for it, the operand slot within that collector, and the thread active mask of the warp. The block hands each operand back to its collector after a programmable number of cycles. Alongside the operands it keeps a running register-file read-activity total.

With a latency of zero and nothing waiting, operands pass straight through in the same cycle. With a nonzero latency, each grant is stamped with a due time and pushed into an in-order ring. Entries leave from the head once they are due, up to one per bank per cycle. When the ring cannot take a full cycle of grants, the block asserts backpressure to the arbiter, so nothing is ever dropped.

Each delivered operand adds to the activity total. With lane-group gating off, it adds the full warp width. With gating on, it adds the group width once for every lane group that holds at least one active thread.

Top module: `operand_delay_queue`

## Requirements
- R1: While reset is held and in the first cycle after release, no delivery is valid, `grant_rdy_o` is 1 and `act_cnt_o` is 0.
- R2: When `latency_i` is 0 and the queue is empty, each valid grant on bank b appears in the same cycle on delivery lane b, carrying its collector ID and operand index.
- R3: When `latency_i` is L > 0, a read granted in cycle t is delivered in cycle t+L, provided no older entry is still waiting.
- R4: Entries leave strictly in arrival order. An entry that is already due waits behind a head entry that is not yet due.
- R5: Up to NUM_BANKS entries drain in one cycle. They occupy lanes 0 upward with no gaps and in queue order. Grants accepted in the same cycle are queued in ascending bank order.
- R6: A delivery is valid for exactly one cycle. Lane k carries collector ID on `dlv_cu_o[k*CU_W +: CU_W]` and operand index on `dlv_opnd_o[k*OPND_W +: OPND_W]`. Grants use the same layout on `grant_cu_i`/`grant_opnd_i`, and the mask of bank b is `grant_mask_i[b*WARP_SIZE +: WARP_SIZE]`.
- R7: With `gate_en_i` = 1 in the delivery cycle, a delivered operand adds GATE_GRP for each group of GATE_GRP consecutive lanes (group g = lanes g*GATE_GRP .. g*GATE_GRP+GATE_GRP-1) that has at least one active bit.
- R8: With `gate_en_i` = 0 in the delivery cycle, every delivered operand adds WARP_SIZE, whatever its mask holds.
- R9: `act_cnt_o` changes at the clock edge that ends a delivery cycle, by the sum over all lanes of that cycle. It holds its value across cycles with no delivery.
- R10: `grant_rdy_o` is 0 exactly when fewer than NUM_BANKS queue slots are free. Every grant accepted while it is 1 is delivered later.
- R11: When `latency_i` is 0 while older entries are still queued, new grants are queued as already due. They deliver behind those entries, no earlier than the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| latency_i | input | LAT_W | Read latency in cycles applied to new grants |
| gate_en_i | input | 1 | Lane-group gating for activity counting |
| grant_vld_i | input | NUM_BANKS | Per-bank grant valid |
| grant_cu_i | input | NUM_BANKS*CU_W | Per-bank collector unit ID |
| grant_opnd_i | input | NUM_BANKS*OPND_W | Per-bank operand index |
| grant_mask_i | input | NUM_BANKS*WARP_SIZE | Per-bank thread active mask |
| grant_rdy_o | output | 1 | Room for a full cycle of grants |
| dlv_vld_o | output | NUM_BANKS | Per-lane delivery pulse |
| dlv_cu_o | output | NUM_BANKS*CU_W | Per-lane collector unit ID |
| dlv_opnd_o | output | NUM_BANKS*OPND_W | Per-lane operand index |
| act_cnt_o | output | ACT_W | Accumulated register-file read activity |

## Verification
A wrong occupancy count shows at `grant_rdy_o` in the next cycle. It also shows as a delivery lane that pulses when nothing was due, or stays quiet when something was. A wrong due-time stamp or a wrong head pointer moves a delivery off its cycle, or swaps collector IDs between lanes. Both are visible at the delivery ports in the very cycle the operand should have left. A wrong gating weight shifts `act_cnt_o` one edge after the affected delivery, and the error persists in every later value.

// File: rtl/odq_pkg.sv
package odq_pkg;
  typedef enum logic {
    SRC_QUEUE  = 1'b0,
    SRC_BYPASS = 1'b1
  } dlv_src_e;

  // due when now has reached or passed the stamp (modular compare)
  function automatic logic ts_due(input logic [31:0] diff_msb_ext);
    return ~diff_msb_ext[0];
  endfunction
endpackage

// File: rtl/odq_ring.sv
module odq_ring #(
  parameter int NB    = 4,
  parameter int DEPTH = 16,
  parameter int ENT_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int NUM_W = $clog2(NB + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NB-1:0]             wr_vld_i,
  input  logic [NB-1:0][ENT_W-1:0]  wr_data_i,
  input  logic [NUM_W-1:0]          rd_num_i,
  output logic [NB-1:0][ENT_W-1:0]  rd_data_o,
  output logic [NB-1:0]             rd_avail_o,
  output logic [CNT_W-1:0]          cnt_o
);
  logic [DEPTH-1:0][ENT_W-1:0] mem_q;
  logic [PTR_W-1:0]            wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [NB-1:0][PTR_W-1:0]    slot;
  logic [NUM_W-1:0]            wr_num;

  // compact valid writes in bank order
  always_comb begin
    logic [NUM_W-1:0] acc;
    acc = '0;
    for (int b = 0; b < NB; b++) begin
      slot[b] = PTR_W'(acc);
      if (wr_vld_i[b]) acc = acc + 1'b1;
    end
    wr_num = acc;
  end

  always_ff @(posedge clk_i) begin
    for (int b = 0; b < NB; b++) begin
      if (wr_vld_i[b]) mem_q[wr_ptr_q + slot[b]] <= wr_data_i[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + PTR_W'(wr_num);
      rd_ptr_q <= rd_ptr_q + PTR_W'(rd_num_i);
      cnt_q    <= cnt_q + CNT_W'(wr_num) - CNT_W'(rd_num_i);
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_rd
    assign rd_data_o[k]  = mem_q[rd_ptr_q + PTR_W'(k)];
    assign rd_avail_o[k] = cnt_q > CNT_W'(k);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/odq_drain.sv
module odq_drain #(
  parameter int NB   = 4,
  parameter int TS_W = 8,
  localparam int NUM_W = $clog2(NB + 1)
) (
  input  logic [NB-1:0]            avail_i,
  input  logic [NB-1:0][TS_W-1:0]  ts_i,
  input  logic [TS_W-1:0]          now_i,
  output logic [NB-1:0]            take_o,
  output logic [NUM_W-1:0]         take_num_o
);
  // contiguous prefix of due entries from the head
  always_comb begin
    logic            run;
    logic [TS_W-1:0] diff;
    logic [NUM_W-1:0] n;
    run = 1'b1;
    n   = '0;
    for (int k = 0; k < NB; k++) begin
      diff      = now_i - ts_i[k];
      take_o[k] = run & avail_i[k] & odq_pkg::ts_due(32'(diff[TS_W-1]));
      run       = take_o[k];
      if (take_o[k]) n = n + 1'b1;
    end
    take_num_o = n;
  end
endmodule

// File: rtl/odq_weight.sv
module odq_weight #(
  parameter int WARP = 32,
  parameter int GRP  = 4,
  localparam int NG   = WARP / GRP,
  localparam int WT_W = $clog2(WARP + 1)
) (
  input  logic [WARP-1:0] mask_i,
  input  logic            gate_en_i,
  output logic [WT_W-1:0] weight_o
);
  logic [NG-1:0] grp_on;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_on[g] = |mask_i[g*GRP +: GRP];
  end

  assign weight_o = gate_en_i ? WT_W'($countones(grp_on) * GRP) : WT_W'(WARP);
endmodule

// File: rtl/operand_delay_queue.sv
module operand_delay_queue #(
  parameter int NUM_BANKS = 4,
  parameter int DEPTH     = 16,
  parameter int LAT_W     = 4,
  parameter int CU_W      = 3,
  parameter int OPND_W    = 2,
  parameter int WARP_SIZE = 32,
  parameter int GATE_GRP  = 4,
  parameter int ACT_W     = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [LAT_W-1:0]               latency_i,
  input  logic                           gate_en_i,
  input  logic [NUM_BANKS-1:0]           grant_vld_i,
  input  logic [NUM_BANKS*CU_W-1:0]      grant_cu_i,
  input  logic [NUM_BANKS*OPND_W-1:0]    grant_opnd_i,
  input  logic [NUM_BANKS*WARP_SIZE-1:0] grant_mask_i,
  output logic                           grant_rdy_o,
  output logic [NUM_BANKS-1:0]           dlv_vld_o,
  output logic [NUM_BANKS*CU_W-1:0]      dlv_cu_o,
  output logic [NUM_BANKS*OPND_W-1:0]    dlv_opnd_o,
  output logic [ACT_W-1:0]               act_cnt_o
);
  import odq_pkg::*;

  localparam int NB    = NUM_BANKS;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int TS_W  = LAT_W + PTR_W + 2;
  localparam int ENT_W = WARP_SIZE + CU_W + OPND_W + TS_W;
  localparam int NUM_W = $clog2(NB + 1);
  localparam int WT_W  = $clog2(WARP_SIZE + 1);
  localparam int INC_W = WT_W + $clog2(NB) + 1;

  typedef struct packed {
    logic [WARP_SIZE-1:0] mask;
    logic [CU_W-1:0]      cu;
    logic [OPND_W-1:0]    opnd;
    logic [TS_W-1:0]      ts;
  } ent_t;

  logic [TS_W-1:0]           now_q;
  logic [CNT_W-1:0]          q_cnt;
  dlv_src_e                  src;
  logic [NB-1:0]             wr_vld;
  logic [NB-1:0][ENT_W-1:0]  wr_data;
  logic [NB-1:0][ENT_W-1:0]  rd_data;
  logic [NB-1:0]             rd_avail;
  logic [NB-1:0][TS_W-1:0]   hd_ts;
  logic [NB-1:0]             take;
  logic [NUM_W-1:0]          take_num;
  logic [NB-1:0]             ln_vld;
  logic [NB-1:0][CU_W-1:0]   ln_cu;
  logic [NB-1:0][OPND_W-1:0] ln_opnd;
  logic [NB-1:0][WARP_SIZE-1:0] ln_mask;
  logic [NB-1:0][WT_W-1:0]   ln_wt;
  logic [INC_W-1:0]          act_inc;
  logic [ACT_W-1:0]          act_q;
  logic [TS_W-1:0]           ts_new;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= '0;
    else         now_q <= now_q + 1'b1;
  end

  assign src         = (latency_i == '0 && q_cnt == '0) ? SRC_BYPASS : SRC_QUEUE;
  assign grant_rdy_o = q_cnt <= CNT_W'(DEPTH - NB);
  assign wr_vld      = grant_vld_i & {NB{grant_rdy_o && src == SRC_QUEUE}};
  assign ts_new      = now_q + TS_W'(latency_i);

  for (genvar b = 0; b < NB; b++) begin : g_wr
    ent_t e;
    assign e.mask  = grant_mask_i[b*WARP_SIZE +: WARP_SIZE];
    assign e.cu    = grant_cu_i[b*CU_W +: CU_W];
    assign e.opnd  = grant_opnd_i[b*OPND_W +: OPND_W];
    assign e.ts    = ts_new;
    assign wr_data[b] = e;
  end

  odq_ring #(.NB(NB), .DEPTH(DEPTH), .ENT_W(ENT_W)) u_ring (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_vld_i   (wr_vld),
    .wr_data_i  (wr_data),
    .rd_num_i   (take_num),
    .rd_data_o  (rd_data),
    .rd_avail_o (rd_avail),
    .cnt_o      (q_cnt)
  );

  for (genvar k = 0; k < NB; k++) begin : g_hd
    ent_t h;
    assign h        = ent_t'(rd_data[k]);
    assign hd_ts[k] = h.ts;

    always_comb begin
      if (src == SRC_BYPASS) begin
        ln_vld[k]  = grant_vld_i[k];
        ln_cu[k]   = grant_cu_i[k*CU_W +: CU_W];
        ln_opnd[k] = grant_opnd_i[k*OPND_W +: OPND_W];
        ln_mask[k] = grant_mask_i[k*WARP_SIZE +: WARP_SIZE];
      end else begin
        ln_vld[k]  = take[k];
        ln_cu[k]   = h.cu;
        ln_opnd[k] = h.opnd;
        ln_mask[k] = h.mask;
      end
    end

    odq_weight #(.WARP(WARP_SIZE), .GRP(GATE_GRP)) u_wt (
      .mask_i    (ln_mask[k]),
      .gate_en_i (gate_en_i),
      .weight_o  (ln_wt[k])
    );

    assign dlv_cu_o[k*CU_W +: CU_W]       = ln_vld[k] ? ln_cu[k] : '0;
    assign dlv_opnd_o[k*OPND_W +: OPND_W] = ln_vld[k] ? ln_opnd[k] : '0;
  end

  odq_drain #(.NB(NB), .TS_W(TS_W)) u_drain (
    .avail_i    (rd_avail),
    .ts_i       (hd_ts),
    .now_i      (now_q),
    .take_o     (take),
    .take_num_o (take_num)
  );

  always_comb begin
    act_inc = '0;
    for (int k = 0; k < NB; k++) begin
      if (ln_vld[k]) act_inc = act_inc + INC_W'(ln_wt[k]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_q + ACT_W'(act_inc);
  end

  assign dlv_vld_o = ln_vld;
  assign act_cnt_o = act_q;
endmodule

// File: rtl/odq_chk.sv
module odq_chk #(
  parameter int NB    = 4,
  parameter int DEPTH = 16,
  parameter int LAT_W = 4,
  parameter int CNT_W = 5,
  parameter int ACT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LAT_W-1:0] latency_i,
  input logic [NB-1:0]    grant_vld_i,
  input logic             grant_rdy_o,
  input logic [NB-1:0]    dlv_vld_o,
  input logic [ACT_W-1:0] act_cnt_o,
  input logic [CNT_W-1:0] q_cnt_i
);
  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_cnt_i <= CNT_W'(DEPTH));

  // R10
  rdy_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_rdy_o |-> q_cnt_i > CNT_W'(DEPTH - NB));

  // R2
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latency_i == '0 && q_cnt_i == '0) |-> dlv_vld_o == grant_vld_i);

  // R3
  empty_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latency_i != '0 && q_cnt_i == '0) |-> dlv_vld_o == '0);

  // R5
  prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_cnt_i != '0) |-> ((dlv_vld_o & (dlv_vld_o + 1'b1)) == '0));

  // R5
  drain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_cnt_i != '0) |-> $countones(dlv_vld_o) <= int'(q_cnt_i));

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_vld_o == '0) |=> $stable(act_cnt_o));
endmodule

bind operand_delay_queue odq_chk #(
  .NB(NUM_BANKS), .DEPTH(DEPTH), .LAT_W(LAT_W), .CNT_W(CNT_W), .ACT_W(ACT_W)
) u_odq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .latency_i   (latency_i),
  .grant_vld_i (grant_vld_i),
  .grant_rdy_o (grant_rdy_o),
  .dlv_vld_o   (dlv_vld_o),
  .act_cnt_o   (act_cnt_o),
  .q_cnt_i     (q_cnt)
);

// File: tb/operand_delay_queue_tb_top.sv
module operand_delay_queue_tb_top;
  localparam int NB    = 4;
  localparam int DEPTH = 16;
  localparam int LAT_W = 4;
  localparam int CU_W  = 3;
  localparam int OP_W  = 2;
  localparam int WARP  = 32;
  localparam int GRP   = 4;
  localparam int ACT_W = 32;

  typedef struct {
    int cu;
    int op;
    logic [WARP-1:0] mask;
    int rt;
  } ment_t;

  logic                 clk_i = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [LAT_W-1:0]     latency_i = '0;
  logic                 gate_en_i = 1'b0;
  logic [NB-1:0]        grant_vld_i = '0;
  logic [NB*CU_W-1:0]   grant_cu_i = '0;
  logic [NB*OP_W-1:0]   grant_opnd_i = '0;
  logic [NB*WARP-1:0]   grant_mask_i = '0;
  logic                 grant_rdy_o;
  logic [NB-1:0]        dlv_vld_o;
  logic [NB*CU_W-1:0]   dlv_cu_o;
  logic [NB*OP_W-1:0]   dlv_opnd_o;
  logic [ACT_W-1:0]     act_cnt_o;

  ment_t      mq[$];
  int         now_m = 0;
  logic [ACT_W-1:0] act_m = '0;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #4 clk_i = ~clk_i;

  operand_delay_queue #(
    .NUM_BANKS(NB), .DEPTH(DEPTH), .LAT_W(LAT_W), .CU_W(CU_W), .OPND_W(OP_W),
    .WARP_SIZE(WARP), .GATE_GRP(GRP), .ACT_W(ACT_W)
  ) dut_i (
    .clk_i, .rst_ni, .latency_i, .gate_en_i, .grant_vld_i, .grant_cu_i,
    .grant_opnd_i, .grant_mask_i, .grant_rdy_o, .dlv_vld_o, .dlv_cu_o,
    .dlv_opnd_o, .act_cnt_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0d exp %0d (cycle %0d)", req, what, act, exp, now_m);
    end
  endtask

  function automatic int wfun(input logic [WARP-1:0] m, input bit g);
    int c = 0;
    if (!g) return WARP;
    for (int i = 0; i < WARP / GRP; i++) if (|m[i*GRP +: GRP]) c += GRP;
    return c;
  endfunction

  task automatic cyc(input logic [NB-1:0] v, input logic [NB*CU_W-1:0] cu,
                     input logic [NB*OP_W-1:0] op, input logic [NB*WARP-1:0] mk,
                     input logic [LAT_W-1:0] lat, input bit gate);
    int size, n, inc;
    bit byp;
    logic [NB-1:0] ev;
    int ecu[NB];
    int eop[NB];
    string tag;
    @(negedge clk_i);
    if (!grant_rdy_o) v = '0;
    grant_vld_i = v; grant_cu_i = cu; grant_opnd_i = op; grant_mask_i = mk;
    latency_i = lat; gate_en_i = gate;
    #1;
    size = mq.size();
    chk(grant_rdy_o == ((DEPTH - size) >= NB), "R10", "grant_rdy",
        grant_rdy_o, (DEPTH - size) >= NB);
    chk(act_cnt_o == act_m, "R7 R8 R9", "act_cnt", act_cnt_o, act_m);
    byp = (lat == 0) && (size == 0);
    ev = '0; inc = 0;
    foreach (ecu[k]) begin ecu[k] = 0; eop[k] = 0; end
    if (byp) begin
      tag = "R2";
      for (int b = 0; b < NB; b++) if (v[b]) begin
        ev[b] = 1'b1;
        ecu[b] = int'(cu[b*CU_W +: CU_W]);
        eop[b] = int'(op[b*OP_W +: OP_W]);
        inc += wfun(mk[b*WARP +: WARP], gate);
      end
    end else begin
      tag = (lat == 0) ? "R11 R4" : "R3 R4 R5";
      n = 0;
      while (n < NB && n < mq.size() && mq[n].rt <= now_m) begin
        ev[n] = 1'b1; ecu[n] = mq[n].cu; eop[n] = mq[n].op;
        inc += wfun(mq[n].mask, gate);
        n++;
      end
      repeat (n) void'(mq.pop_front());
      for (int b = 0; b < NB; b++) if (v[b])
        mq.push_back('{cu: int'(cu[b*CU_W +: CU_W]), op: int'(op[b*OP_W +: OP_W]),
                       mask: mk[b*WARP +: WARP], rt: now_m + int'(lat)});
    end
    chk(dlv_vld_o == ev, tag, "dlv_vld", dlv_vld_o, ev);
    for (int k = 0; k < NB; k++) if (ev[k] && dlv_vld_o[k]) begin
      chk(int'(dlv_cu_o[k*CU_W +: CU_W]) == ecu[k], "R6", "dlv_cu",
          dlv_cu_o[k*CU_W +: CU_W], ecu[k]);
      chk(int'(dlv_opnd_o[k*OP_W +: OP_W]) == eop[k], "R6", "dlv_opnd",
          dlv_opnd_o[k*OP_W +: OP_W], eop[k]);
    end
    act_m += ACT_W'(inc);
    now_m++;
  endtask

  task automatic idle(input int n, input logic [LAT_W-1:0] lat, input bit gate);
    for (int i = 0; i < n; i++) cyc('0, '0, '0, '0, lat, gate);
  endtask

  task automatic one(input int bank, input int cu, input int op,
                     input logic [WARP-1:0] m, input logic [LAT_W-1:0] lat, input bit gate);
    logic [NB-1:0] v = '0;
    logic [NB*CU_W-1:0] c = '0;
    logic [NB*OP_W-1:0] o = '0;
    logic [NB*WARP-1:0] mm = '0;
    v[bank] = 1'b1;
    c[bank*CU_W +: CU_W] = CU_W'(cu);
    o[bank*OP_W +: OP_W] = OP_W'(op);
    mm[bank*WARP +: WARP] = m;
    cyc(v, c, o, mm, lat, gate);
  endtask

  task automatic rnd(input logic [LAT_W-1:0] lat, input bit gate, input bit full);
    logic [NB*WARP-1:0] mm;
    for (int b = 0; b < NB; b++) begin
      case ($urandom % 4)
        0: mm[b*WARP +: WARP] = '1;
        1: mm[b*WARP +: WARP] = '0;
        2: mm[b*WARP +: WARP] = WARP'($urandom);
        default: mm[b*WARP +: WARP] = WARP'(1) << ($urandom % WARP);
      endcase
    end
    cyc(full ? '1 : NB'($urandom), NB*CU_W'($urandom), NB*OP_W'($urandom), mm, lat, gate);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [LAT_W-1:0] lat_cur;
    void'($urandom(32'h1d5e));
    repeat (2) @(negedge clk_i);
    #1;
    // R1 during reset
    chk(dlv_vld_o == '0, "R1", "dlv_vld in reset", dlv_vld_o, 0);
    chk(grant_rdy_o == 1'b1, "R1", "rdy in reset", grant_rdy_o, 1);
    chk(act_cnt_o == '0, "R1", "act in reset", act_cnt_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(dlv_vld_o == '0, "R1", "dlv_vld after reset", dlv_vld_o, 0);
    chk(act_cnt_o == '0, "R1", "act after reset", act_cnt_o, 0);

    // R2 bypass, R8 ungated weight, R7 gated weight (lanes 0 and 4 -> 8)
    cyc(4'b1011, 12'o7531, 8'b11100100, {4{32'h0000_0011}}, 4'd0, 1'b0);
    cyc(4'b0100, 12'o0600, 8'b00100000, {4{32'h0000_0011}}, 4'd0, 1'b1);
    idle(2, 4'd0, 1'b1);

    // R3 single read at latency 3
    one(2, 5, 1, 32'hF000_0001, 4'd3, 1'b1);
    idle(5, 4'd3, 1'b1);

    // R4 head-of-line: latency 8 then latency 1; R5 both drain together
    one(0, 1, 0, 32'h1, 4'd8, 1'b0);
    one(3, 2, 3, 32'h2, 4'd1, 1'b0);
    idle(10, 4'd1, 1'b0);

    // R11 latency drops to zero behind a waiting entry
    one(1, 3, 2, 32'hFF, 4'd5, 1'b1);
    one(2, 4, 1, 32'hFF00, 4'd0, 1'b1);
    idle(8, 4'd0, 1'b1);

    // R10 fill to backpressure with all banks, then drain
    for (int i = 0; i < 7; i++) rnd(4'd15, 1'b1, 1'b1);
    idle(24, 4'd15, 1'b0);

    // mixed random traffic
    lat_cur = 4'd2;
    for (int i = 0; i < 3000; i++) begin
      if (i % 60 == 0) lat_cur = ($urandom % 5 == 0) ? 4'd0 : LAT_W'($urandom);
      if ($urandom % 8 == 0) cyc('0, '0, '0, '0, lat_cur, 1'($urandom));
      else rnd(lat_cur, 1'($urandom), ($urandom % 6 == 0));
    end
    idle(40, 4'd1, 1'b0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule